// File: doc/BRIEF.md
# Segmented Wide XOR Reducer

This block takes two 58-bit operand buses, treats them as one 116-bit word (low bus in the lower half), and returns XOR parities over segments of that word. A size select chooses how finely the word is cut: fine segments of 12 and 22 bits, medium segments of 24 and 34 bits, one segment per 58-bit half, or a single parity over all 116 bits. The segment widths inside a half always add up to exactly 58 bits, so every operand bit lands in exactly one segment in every mode.

The result is an 8-bit parity vector held in a register. A clock enable controls when the register loads. A separate XOR enable gates the reduction logic off to save power. While the XOR enable is low, the operands are forced to zero at the logic input and the register keeps its value. A synchronous reset clears the register. The size select is meant to stay fixed for a given use, but it is sampled on every enabled cycle.

Top module: `seg_xor_reducer`

## Requirements
- R1: With size_sel = 2'b00 (fine), each half is cut from its LSB upward into segments of 12, 12, 12 and 22 bits. par_out[3:0] carry the low-half segment parities and par_out[7:4] the high-half ones, ordered from least- to most-significant segment.
- R2: With size_sel = 2'b01 (medium), each half is cut into a 24-bit low segment and a 34-bit high segment. par_out[0] and par_out[1] hold the low half's 24-bit and 34-bit parities, and par_out[2] and par_out[3] hold the high half's.
- R3: With size_sel = 2'b10 (wide), par_out[0] is the parity of opnd_lo and par_out[1] is the parity of opnd_hi.
- R4: With size_sel = 2'b11 (full), par_out[0] is the parity of all 116 operand bits.
- R5: Output bits that the selected mode does not use are zero: par_out[7:4] in medium mode, par_out[7:2] in wide mode, par_out[7:1] in full mode.
- R6: When ce and xor_en are both high at a rising edge, par_out shows the result for the operands and size_sel sampled at that edge, starting just after that edge (one cycle of latency).
- R7: When ce is low at a rising edge and rst is low, par_out keeps its value, whatever the operands or size_sel do.
- R8: When xor_en is low at a rising edge and rst is low, par_out keeps its value, even if ce is high and the operands change.
- R9: When rst is high at a rising edge, par_out becomes 8'h00, whatever ce and xor_en are.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous reset, active high; clears the result |
| ce | input | 1 | Clock enable for the result register |
| xor_en | input | 1 | Enables the reduction logic; low gates the logic off and holds the result |
| size_sel | input | 2 | Segment size: 00 fine, 01 medium, 10 wide, 11 full |
| opnd_lo | input | 58 | Lower half of the 116-bit word |
| opnd_hi | input | 58 | Upper half of the 116-bit word |
| par_out | output | 8 | Registered segment parities, least-significant segment in bit 0 |

## Verification
Single set bits are placed on both sides of each segment boundary (bits 11/12, 23/24, 35/36, 57/58) in every mode. A misplaced boundary or a swapped output bit then shows up as a parity that moves to the wrong output position. All-ones and alternating patterns separate even-width from odd-count segments and expose a wrong segment width: a 22-bit segment of ones has even parity, while a segment wrongly sized to 23 bits would not. Random words in all four modes, mixed with random low ce, xor_en and rst, compare the full vector against a bit-by-bit model. This exposes a missing zero on unused outputs, a hold that fails while gated, and a reset that loses priority.

// File: rtl/seg_xor_pkg.sv
package seg_xor_pkg;

   typedef enum logic [1:0] {
      SZ_FINE = 2'b00,
      SZ_MED  = 2'b01,
      SZ_WIDE = 2'b10,
      SZ_FULL = 2'b11
   } seg_size_e;

   localparam int unsigned SEGS_PER_HALF = 4;
   localparam int unsigned NUM_HALVES    = 2;
   localparam int unsigned PAR_W         = SEGS_PER_HALF * NUM_HALVES;

   // lowest bit of fine segment idx inside one half
   function automatic int unsigned fine_seg_base(input int unsigned idx,
                                                 input int unsigned fine_w);
      return idx * fine_w;
   endfunction

   // width of fine segment idx; the top segment takes the remainder
   function automatic int unsigned fine_seg_width(input int unsigned idx,
                                                  input int unsigned fine_w,
                                                  input int unsigned half_w);
      if (idx == SEGS_PER_HALF - 1) return half_w - (SEGS_PER_HALF - 1) * fine_w;
      return fine_w;
   endfunction

endpackage

// File: rtl/seg_xor_slice.sv
module seg_xor_slice #(
   parameter int unsigned SLICE_W = 12
) (
   input  logic [SLICE_W-1:0] slice_in,
   output logic               slice_par
);

   generate
      if (SLICE_W < 1) begin : g_bad_width
         $error("seg_xor_slice: SLICE_W must be at least 1");
      end
   endgenerate

   assign slice_par = ^slice_in;

endmodule

// File: rtl/seg_xor_half.sv
module seg_xor_half
   import seg_xor_pkg::*;
#(
   parameter int unsigned HALF_W = 58,
   parameter int unsigned FINE_W = 12
) (
   input  logic [HALF_W-1:0]        half_in,
   output logic [SEGS_PER_HALF-1:0] fine_par
);

   localparam int unsigned TOP_W = HALF_W - (SEGS_PER_HALF - 1) * FINE_W;

   generate
      if (FINE_W < 1 || HALF_W <= (SEGS_PER_HALF - 1) * FINE_W) begin : g_bad_split
         $error("seg_xor_half: HALF_W must exceed three fine segments");
      end
      if (TOP_W < FINE_W) begin : g_bad_top
         $error("seg_xor_half: top fine segment narrower than the others");
      end
   endgenerate

   for (genvar s = 0; s < SEGS_PER_HALF; s++) begin : g_seg
      localparam int unsigned S_LO = fine_seg_base(s, FINE_W);
      localparam int unsigned S_W  = fine_seg_width(s, FINE_W, HALF_W);

      seg_xor_slice #(
         .SLICE_W (S_W)
      ) u_slice (
         .slice_in  (half_in[S_LO +: S_W]),
         .slice_par (fine_par[s])
      );
   end

endmodule

// File: rtl/seg_xor_merge.sv
module seg_xor_merge
   import seg_xor_pkg::*;
(
   input  seg_size_e                size,
   input  logic [SEGS_PER_HALF-1:0] fine_lo,
   input  logic [SEGS_PER_HALF-1:0] fine_hi,
   output logic [PAR_W-1:0]         merged
);

   logic med_lo_a, med_lo_b, med_hi_a, med_hi_b;
   logic half_lo, half_hi;

   // medium segments are pairs of adjacent fine segments
   always_comb begin
      med_lo_a = fine_lo[0] ^ fine_lo[1];
      med_lo_b = fine_lo[2] ^ fine_lo[3];
      med_hi_a = fine_hi[0] ^ fine_hi[1];
      med_hi_b = fine_hi[2] ^ fine_hi[3];
      half_lo  = med_lo_a ^ med_lo_b;
      half_hi  = med_hi_a ^ med_hi_b;
   end

   always_comb begin
      merged = '0;
      unique case (size)
         SZ_FINE: merged = {fine_hi, fine_lo};
         SZ_MED:  merged[3:0] = {med_hi_b, med_hi_a, med_lo_b, med_lo_a};
         SZ_WIDE: merged[1:0] = {half_hi, half_lo};
         SZ_FULL: merged[0]   = half_lo ^ half_hi;
         default: merged = '0;
      endcase
   end

endmodule

// File: rtl/seg_xor_reducer.sv
module seg_xor_reducer
   import seg_xor_pkg::*;
#(
   parameter int unsigned HALF_W = 58,
   parameter int unsigned FINE_W = 12
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              ce,
   input  logic              xor_en,
   input  logic [1:0]        size_sel,
   input  logic [HALF_W-1:0] opnd_lo,
   input  logic [HALF_W-1:0] opnd_hi,
   output logic [7:0]        par_out
);

   generate
      if (PAR_W != 8) begin : g_bad_par
         $error("seg_xor_reducer: output vector must be 8 bits");
      end
   endgenerate

   logic [HALF_W-1:0]         gated_lo, gated_hi;
   logic [SEGS_PER_HALF-1:0]  fine_lo, fine_hi;
   logic [PAR_W-1:0]          merged;
   logic [PAR_W-1:0]          par_q;
   seg_size_e                 size;

   assign size = seg_size_e'(size_sel);

   // operand isolation: when disabled the tree sees constant zeros
   always_comb begin
      gated_lo = opnd_lo & {HALF_W{xor_en}};
      gated_hi = opnd_hi & {HALF_W{xor_en}};
   end

   seg_xor_half #(
      .HALF_W (HALF_W),
      .FINE_W (FINE_W)
   ) u_half_lo (
      .half_in  (gated_lo),
      .fine_par (fine_lo)
   );

   seg_xor_half #(
      .HALF_W (HALF_W),
      .FINE_W (FINE_W)
   ) u_half_hi (
      .half_in  (gated_hi),
      .fine_par (fine_hi)
   );

   seg_xor_merge u_merge (
      .size    (size),
      .fine_lo (fine_lo),
      .fine_hi (fine_hi),
      .merged  (merged)
   );

   always_ff @(posedge clk) begin
      if (rst)                 par_q <= '0;
      else if (ce && xor_en)   par_q <= merged;
   end

   assign par_out = par_q;

endmodule

// File: rtl/seg_xor_reducer_chk.sv
module seg_xor_reducer_chk #(
   parameter int unsigned HALF_W = 58
) (
   input logic              clk,
   input logic              rst,
   input logic              ce,
   input logic              xor_en,
   input logic [1:0]        size_sel,
   input logic [HALF_W-1:0] opnd_lo,
   input logic [HALF_W-1:0] opnd_hi,
   input logic [7:0]        par_out
);

   logic load;
   assign load = ce && xor_en;

   // R9
   p_reset_clear_r9: assert property (@(posedge clk) rst |=> (par_out == 8'h00))
      else $error("reset did not clear the result");

   // R7
   p_hold_ce_r7: assert property (@(posedge clk) disable iff (rst)
      !ce |=> $stable(par_out))
      else $error("result changed with ce low");

   // R8
   p_hold_gate_r8: assert property (@(posedge clk) disable iff (rst)
      !xor_en |=> $stable(par_out))
      else $error("result changed while gated off");

   // R5
   p_unused_med_r5: assert property (@(posedge clk) disable iff (rst)
      (load && size_sel == 2'b01) |=> (par_out[7:4] == 4'h0))
      else $error("medium mode drove unused bits");

   p_unused_wide_r5: assert property (@(posedge clk) disable iff (rst)
      (load && size_sel == 2'b10) |=> (par_out[7:2] == 6'h00))
      else $error("wide mode drove unused bits");

   // R3
   p_wide_par_r3: assert property (@(posedge clk) disable iff (rst)
      (load && size_sel == 2'b10) |=>
         (par_out[0] == $past(^opnd_lo) && par_out[1] == $past(^opnd_hi)))
      else $error("wide parity mismatch");

   // R4
   p_full_par_r4: assert property (@(posedge clk) disable iff (rst)
      (load && size_sel == 2'b11) |=>
         (par_out == {7'h00, $past(^{opnd_hi, opnd_lo})}))
      else $error("full parity mismatch");

endmodule

bind seg_xor_reducer seg_xor_reducer_chk #(
   .HALF_W (HALF_W)
) u_chk (
   .clk      (clk),
   .rst      (rst),
   .ce       (ce),
   .xor_en   (xor_en),
   .size_sel (size_sel),
   .opnd_lo  (opnd_lo),
   .opnd_hi  (opnd_hi),
   .par_out  (par_out)
);

// File: tb/seg_xor_reducer_tb.sv
module seg_xor_reducer_tb;

   localparam int HW = 58;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic          ce = 1'b0;
   logic          xor_en = 1'b0;
   logic [1:0]    size_sel = 2'b00;
   logic [HW-1:0] opnd_lo = '0;
   logic [HW-1:0] opnd_hi = '0;
   logic [7:0]    par_out;

   int n_checks = 0;
   int n_errors = 0;
   logic [7:0] exp_q = 8'h00;

   always #2 clk = ~clk;

   seg_xor_reducer u_dut (
      .clk      (clk),
      .rst      (rst),
      .ce       (ce),
      .xor_en   (xor_en),
      .size_sel (size_sel),
      .opnd_lo  (opnd_lo),
      .opnd_hi  (opnd_hi),
      .par_out  (par_out)
   );

   // reference model, written bit by bit from the requirements
   function automatic logic [7:0] model(input logic [HW-1:0] lo,
                                        input logic [HW-1:0] hi,
                                        input logic [1:0] sz);
      logic [7:0] r;
      logic [115:0] w;
      r = '0;
      w = {hi, lo};
      for (int b = 0; b < 116; b++) begin
         int h, pos, seg;
         h   = b / HW;
         pos = b % HW;
         case (sz)
            2'b00: begin
               seg = (pos < 12) ? 0 : (pos < 24) ? 1 : (pos < 36) ? 2 : 3;
               r[h*4 + seg] ^= w[b];
            end
            2'b01: begin
               seg = (pos < 24) ? 0 : 1;
               r[h*2 + seg] ^= w[b];
            end
            2'b10: r[h] ^= w[b];
            default: r[0] ^= w[b];
         endcase
      end
      return r;
   endfunction

   function automatic string mode_req(input logic [1:0] sz);
      case (sz)
         2'b00: return "R1";
         2'b01: return "R2";
         2'b10: return "R3";
         default: return "R4";
      endcase
   endfunction

   task automatic check(input string req, input logic [7:0] exp);
      n_checks++;
      if (par_out !== exp) begin
         n_errors++;
         $display("FAIL %s: par_out=%02h expected=%02h", req, par_out, exp);
      end
   endtask

   // one cycle: drive at negedge, update model at the edge, sample after it
   task automatic step(input logic r, input logic c, input logic e,
                       input logic [1:0] sz,
                       input logic [HW-1:0] lo, input logic [HW-1:0] hi);
      @(negedge clk);
      rst = r; ce = c; xor_en = e; size_sel = sz; opnd_lo = lo; opnd_hi = hi;
      @(posedge clk);
      if (r)          exp_q = 8'h00;
      else if (c && e) exp_q = model(lo, hi, sz);
      #1;
   endtask

   function automatic logic [HW-1:0] rnd58();
      return {$urandom(), $urandom()};
   endfunction

   initial begin
      #(200000 * 4);
      n_errors++;
      $display("FAIL watchdog: par_out=%02h expected=finish", par_out);
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
   end

   initial begin
      logic [HW-1:0] one58;
      logic [HW-1:0] alt58;
      logic [7:0] held;
      void'($urandom(32'h5EED_2025));
      one58 = '1;
      alt58 = {29{2'b10}};

      // R9: reset state
      step(1, 0, 0, 2'b00, '0, '0);
      check("R9 reset state", 8'h00);

      // R1: single bits at fine boundaries, both halves
      for (int k = 0; k < 8; k++) begin
         int bits[8] = '{0, 11, 12, 23, 24, 35, 36, 57};
         step(0, 1, 1, 2'b00, HW'(1) << bits[k], '0);
         check("R1 lo boundary bit", model(HW'(1) << bits[k], '0, 2'b00));
         step(0, 1, 1, 2'b00, '0, HW'(1) << bits[k]);
         check("R1 hi boundary bit", model('0, HW'(1) << bits[k], 2'b00));
      end
      // R1: all ones, 12-bit and 22-bit segments all even
      step(0, 1, 1, 2'b00, one58, one58);
      check("R1 all ones", 8'h00);

      // R2 and R5: medium boundaries and unused bits
      step(0, 1, 1, 2'b01, HW'(1) << 23, HW'(1) << 24);
      check("R2 medium boundary", 8'b0000_1001);
      step(0, 1, 1, 2'b01, one58 >> 1, alt58);
      check("R5 medium unused zero", model(one58 >> 1, alt58, 2'b01));

      // R3 and R5: wide
      step(0, 1, 1, 2'b10, HW'(1) << 57, one58 >> 1);
      check("R3 wide halves", 8'b0000_0011);
      // R4: full, bit on each side of the half boundary
      step(0, 1, 1, 2'b11, HW'(1) << 57, '0);
      check("R4 full single bit", 8'h01);
      step(0, 1, 1, 2'b11, HW'(1) << 57, HW'(1));
      check("R4 full two bits", 8'h00);

      // R6: one-cycle latency with a fresh value
      step(0, 1, 1, 2'b10, HW'(1), '0);
      check("R6 latency", 8'h01);

      // R7: ce low holds while inputs change
      held = par_out;
      step(0, 0, 1, 2'b00, rnd58(), one58 >> 3);
      check("R7 hold ce low", held);
      step(0, 0, 1, 2'b11, HW'(1), '0);
      check("R7 hold ce low again", held);

      // R8: gated off holds even with ce high
      step(0, 1, 0, 2'b00, alt58, HW'(7));
      check("R8 hold gated", held);
      step(0, 1, 0, 2'b01, HW'(1) << 30, '0);
      check("R8 hold gated again", held);
      // R6: valid one cycle after re-enable
      step(0, 1, 1, 2'b01, HW'(1) << 30, '0);
      check("R6 valid after enable", 8'b0000_0010);

      // R9: reset wins with enables low and with enables high
      step(1, 0, 0, 2'b00, one58, '0);
      check("R9 reset with ce low", 8'h00);
      step(0, 1, 1, 2'b00, HW'(1), '0);
      step(1, 1, 1, 2'b00, HW'(1), '0);
      check("R9 reset over load", 8'h00);

      // random mix
      for (int i = 0; i < 600; i++) begin
         logic r, c, e;
         logic [1:0] sz;
         r  = ($urandom_range(0, 29) == 0);
         c  = ($urandom_range(0, 4) != 0);
         e  = ($urandom_range(0, 4) != 0);
         sz = 2'($urandom_range(0, 3));
         step(r, c, e, sz, rnd58(), rnd58());
         if (r)        check("R9 random reset", exp_q);
         else if (!c)  check("R7 random hold", exp_q);
         else if (!e)  check("R8 random gated", exp_q);
         else          check(mode_req(sz), exp_q);
      end

      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
   end

endmodule